// File: doc/BRIEF.md
# Shared Auxiliary Channel Ownership Arbiter

This block decides which of two masters may drive a shared auxiliary-channel transaction engine: a software host or an embedded microcontroller. A two-bit ownership code on the outputs reports the current holder. The microcontroller is granted the channel in a single step. The host must run an acquire sequence. That sequence first turns on the engine. It then optionally pulses the engine reset and waits for the engine's reset-done flag to rise and then fall. Only after that does it raise the host's access request and take ownership.

The host starts an acquire with a one-cycle pulse on `host_acq`. One cycle-wide pulse then reports the result: `host_ok` or `host_fail`. The host hands the channel back with a one-cycle `host_done` pulse. The microcontroller uses `mc_take` and `mc_drop` pulses. Each reset-done wait is bounded by a cycle limit, so an engine that never responds ends the acquire with a failure instead of hanging it.

Top module: `aux_arb_top`

## Requirements
- R1: After reset, `owner` reads 0 (idle), `eng_en` and `eng_rst` read 0, and `owner` never reads 3. Codes: 0 idle, 1 host, 2 microcontroller.
- R2: A `host_acq` pulse while `owner` is 2 gives a `host_fail` pulse in the next cycle. It changes nothing else: `owner` stays 2 and `eng_rst` stays 0.
- R3: A host acquire from idle sets `eng_en` in the cycle after the request. `eng_en` is high before `eng_rst` is first raised, and it stays high until reset.
- R4: With RESET_USED=1, the acquire raises `eng_rst` and holds it until `rst_done` is seen at 1. It then lowers `eng_rst` and waits until `rst_done` is seen at 0 before requesting ownership.
- R5: The acquire succeeds only if `owner` reads 1 when its request step completes. `host_ok` pulses in that same cycle.
- R6: A `host_done` pulse while `owner` is 1 returns `owner` to 0 in the next cycle. A `host_done` pulse when the host is not the owner has no effect.
- R7: An `mc_take` pulse while `owner` is 0 makes `owner` read 2 in the next cycle. An `mc_drop` pulse while `owner` is 2 returns it to 0.
- R8: If `mc_take` and `host_acq` arrive in the same cycle from idle, `owner` becomes 2 and `host_fail` pulses.
- R9: If a reset-done wait lasts WAIT_LIMIT cycles without its condition being met, the acquire fails: `host_fail` pulses, `eng_rst` is 0 and `owner` stays 0. When the flag never rises, `host_fail` is seen WAIT_LIMIT+1 cycles after the request cycle.
- R10: An `mc_take` pulse during a host acquire sequence wins the channel. The sequence aborts with `host_fail`, `eng_rst` drops to 0 and `owner` becomes 2.
- R11: An `mc_take` pulse while the host owns the channel is ignored, and `owner` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_acq | input | 1 | Host acquire request pulse |
| host_done | input | 1 | Host release pulse |
| mc_take | input | 1 | Microcontroller request pulse |
| mc_drop | input | 1 | Microcontroller release pulse |
| rst_done | input | 1 | Engine reset-done flag |
| owner | output | 2 | Ownership code: 0 idle, 1 host, 2 microcontroller |
| host_ok | output | 1 | Acquire succeeded (one-cycle pulse) |
| host_fail | output | 1 | Acquire refused or failed (one-cycle pulse) |
| eng_en | output | 1 | Engine enable |
| eng_rst | output | 1 | Engine reset |

## Verification
The assertions assume that all request and release inputs are single-cycle pulses. They also assume that `rst_done` changes only in response to `eng_rst`, with no spurious toggling while no acquire is running. The stimulus keeps to these assumptions. A bench responder derives `rst_done` from a delayed copy of `eng_rst`, or holds it stuck to force a timeout. Each host acquire also runs to its `host_ok` or `host_fail` result before the next operation is issued. The only deliberate overlaps are the simultaneous-request and mid-sequence microcontroller cases.

// File: rtl/aux_arb_pkg.sv
package aux_arb_pkg;

  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_MC   = 2'd2
  } owner_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ENABLE,
    SQ_RST_HI,
    SQ_RST_LO,
    SQ_REQUEST
  } seq_t;

  // width of a counter that reaches lim-1
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim > 2) ? $clog2(lim) : 1;
  endfunction

  // a host acquire may begin only from idle with no competing microcontroller take
  function automatic logic host_may_start(input owner_t own, input logic mc_win);
    return (own == OWN_IDLE) && !mc_win;
  endfunction

endpackage

// File: rtl/aux_arb_wait_timer.sv
module aux_arb_wait_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  import aux_arb_pkg::*;

  localparam int unsigned CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (run && cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  // counting step: a running, uncleared timer advances by one
  assert_timer_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

  assert_timer_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/aux_arb_owner.sv
module aux_arb_owner (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_grant,
  input  logic                  host_done,
  input  logic                  mc_take,
  input  logic                  mc_drop,
  output aux_arb_pkg::owner_t   owner,
  output logic                  mc_win
);
  import aux_arb_pkg::*;

  owner_t own_q;

  assign mc_win = mc_take && (own_q == OWN_IDLE);
  assign owner  = own_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q <= OWN_IDLE;
    end else begin
      unique case (own_q)
        OWN_IDLE: begin
          if (mc_win)          own_q <= OWN_MC;
          else if (host_grant) own_q <= OWN_HOST;
        end
        OWN_HOST: if (host_done) own_q <= OWN_IDLE;
        OWN_MC:   if (mc_drop)   own_q <= OWN_IDLE;
        default:  own_q <= OWN_IDLE;
      endcase
    end
  end

  assert_owner_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    own_q != 2'd3);

  assert_mc_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_IDLE && mc_take) |=> (own_q == OWN_MC));

  assert_host_only_by_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_IDLE && !host_grant) |=> (own_q != OWN_HOST));

  assert_mc_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_HOST && !host_done) |=> (own_q == OWN_HOST));

  assert_host_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_HOST && host_done) |=> (own_q == OWN_IDLE));

endmodule

// File: rtl/aux_arb_acq_seq.sv
module aux_arb_acq_seq #(
  parameter bit RESET_USED = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_acq,
  input  logic                 rst_done,
  input  aux_arb_pkg::owner_t  owner,
  input  logic                 mc_win,
  input  logic                 expired,
  output logic                 host_grant,
  output logic                 host_ok,
  output logic                 host_fail,
  output logic                 eng_en,
  output logic                 eng_rst,
  output logic                 tmr_clr,
  output logic                 tmr_run
);
  import aux_arb_pkg::*;

  seq_t st;

  assign tmr_run    = (st == SQ_RST_HI) || (st == SQ_RST_LO);
  assign tmr_clr    = !tmr_run || (st == SQ_RST_HI && rst_done);
  assign host_grant = (st == SQ_REQUEST) && !mc_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      host_ok   <= 1'b0;
      host_fail <= 1'b0;
      eng_en    <= 1'b0;
      eng_rst   <= 1'b0;
    end else begin
      host_ok   <= 1'b0;
      host_fail <= 1'b0;
      if (st == SQ_IDLE) begin
        if (host_acq) begin
          if (owner == OWN_HOST) begin
            host_ok <= 1'b1;
          end else if (host_may_start(owner, mc_win)) begin
            eng_en <= 1'b1;
            st     <= SQ_ENABLE;
          end else begin
            host_fail <= 1'b1;
          end
        end
      end else if (mc_win) begin
        host_fail <= 1'b1;
        eng_rst   <= 1'b0;
        st        <= SQ_IDLE;
      end else begin
        unique case (st)
          SQ_ENABLE: begin
            if (RESET_USED) begin
              eng_rst <= 1'b1;
              st      <= SQ_RST_HI;
            end else begin
              st <= SQ_REQUEST;
            end
          end
          SQ_RST_HI: begin
            if (rst_done) begin
              eng_rst <= 1'b0;
              st      <= SQ_RST_LO;
            end else if (expired) begin
              eng_rst   <= 1'b0;
              host_fail <= 1'b1;
              st        <= SQ_IDLE;
            end
          end
          SQ_RST_LO: begin
            if (!rst_done) begin
              st <= SQ_REQUEST;
            end else if (expired) begin
              host_fail <= 1'b1;
              st        <= SQ_IDLE;
            end
          end
          SQ_REQUEST: begin
            host_ok <= 1'b1;
            st      <= SQ_IDLE;
          end
          default: st <= SQ_IDLE;
        endcase
      end
    end
  end

  assert_refuse_mc_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_IDLE && host_acq && owner == OWN_MC) |=> (host_fail && !eng_rst));

  assert_rst_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |-> eng_en);

  assert_en_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_en |=> eng_en);

  assert_rst_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_RST_HI && !rst_done && !expired && !mc_win) |=> eng_rst);

  assert_ok_with_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ok && !$past(host_acq)) |-> (owner == OWN_HOST));

  assert_result_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_ok, host_fail}));

  assert_timeout_fails_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_run && expired && !mc_win && !(st == SQ_RST_HI && rst_done)
     && !(st == SQ_RST_LO && !rst_done)) |=> (host_fail && !eng_rst));

  assert_mc_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SQ_IDLE && mc_win) |=> (host_fail && !eng_rst && owner == OWN_MC));

endmodule

// File: rtl/aux_arb_top.sv
module aux_arb_top #(
  parameter bit          RESET_USED = 1'b1,
  parameter int unsigned WAIT_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_acq,
  input  logic       host_done,
  input  logic       mc_take,
  input  logic       mc_drop,
  input  logic       rst_done,
  output logic [1:0] owner,
  output logic       host_ok,
  output logic       host_fail,
  output logic       eng_en,
  output logic       eng_rst
);
  import aux_arb_pkg::*;

  owner_t own_w;
  logic   mc_win_w;
  logic   grant_w;
  logic   expired_w;
  logic   tmr_clr_w;
  logic   tmr_run_w;

  aux_arb_owner u_owner (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_grant (grant_w),
    .host_done  (host_done),
    .mc_take    (mc_take),
    .mc_drop    (mc_drop),
    .owner      (own_w),
    .mc_win     (mc_win_w)
  );

  aux_arb_acq_seq #(.RESET_USED(RESET_USED)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_acq   (host_acq),
    .rst_done   (rst_done),
    .owner      (own_w),
    .mc_win     (mc_win_w),
    .expired    (expired_w),
    .host_grant (grant_w),
    .host_ok    (host_ok),
    .host_fail  (host_fail),
    .eng_en     (eng_en),
    .eng_rst    (eng_rst),
    .tmr_clr    (tmr_clr_w),
    .tmr_run    (tmr_run_w)
  );

  aux_arb_wait_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr_w),
    .run     (tmr_run_w),
    .expired (expired_w)
  );

  assign owner = own_w;

  assert_sim_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (own_w == OWN_IDLE && mc_take && host_acq) |=> (owner == 2'd2 && host_fail));

endmodule

// File: tb/sim_aux_arb_top.sv
module sim_aux_arb_top;
  localparam int unsigned WL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_acq = 1'b0, host_done = 1'b0, mc_take = 1'b0, mc_drop = 1'b0;
  logic rst_done = 1'b0;
  logic [1:0] owner;
  logic host_ok, host_fail, eng_en, eng_rst;

  int n_chk = 0;
  int n_fail = 0;
  int mode = 0;        // 0 follow, 1 stuck low, 2 stuck high once set
  int dly = 1;
  logic [7:0] hist = '0;
  logic prev_rst = 1'b0;
  int ord_err = 0;
  logic seen_hi = 1'b0;

  always #10 clk = ~clk;

  aux_arb_top #(.RESET_USED(1'b1), .WAIT_LIMIT(WL)) u0 (
    .clk(clk), .rst_n(rst_n), .host_acq(host_acq), .host_done(host_done),
    .mc_take(mc_take), .mc_drop(mc_drop), .rst_done(rst_done), .owner(owner),
    .host_ok(host_ok), .host_fail(host_fail), .eng_en(eng_en), .eng_rst(eng_rst));

  // reset-done responder and ordering monitor
  always @(negedge clk) begin
    hist <= {hist[6:0], eng_rst};
    case (mode)
      0: rst_done <= hist[dly];
      1: rst_done <= 1'b0;
      default: if (hist[dly]) rst_done <= 1'b1;
    endcase
    if (eng_rst && !prev_rst && !eng_en) ord_err++;
    if (rst_done) seen_hi = 1'b1;
    prev_rst <= eng_rst;
  end

  function automatic int next_owner_acq(input int own);
    return (own == 2) ? 2 : 1;
  endfunction

  function automatic int acq_result(input int own);
    return (own == 2) ? 2 : 1;   // 1 ok, 2 fail
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic host_try(output int res, output int lat);
    res = 0; lat = 0;
    seen_hi = 1'b0;
    @(negedge clk); host_acq = 1'b1;
    @(negedge clk); host_acq = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (host_ok)   begin res = 1; lat = i; break; end
      if (host_fail) begin res = 2; lat = i; break; end
      @(negedge clk);
    end
  endtask

  task automatic settle();
    mode = 0;
    repeat (12) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    int res, lat, exp_own, op;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 owner", owner, 0);
    chk("R1 eng_en", eng_en, 0);
    chk("R1 eng_rst", eng_rst, 0);

    // normal acquire
    dly = 2;
    host_try(res, lat);
    chk("R5 acquire result", res, 1);
    chk("R5 owner", owner, 1);
    chk("R4 saw done high", seen_hi, 1);
    chk("R4 done low at grant", rst_done, 0);
    chk("R3 eng_en", eng_en, 1);
    chk("R3 order", ord_err, 0);
    // mc ignored while host owns
    pulse(mc_take);
    chk("R11 owner kept", owner, 1);
    pulse(host_done);
    chk("R6 release", owner, 0);
    pulse(host_done);
    chk("R6 stray release", owner, 0);

    // mc ownership and refusal
    pulse(mc_take);
    chk("R7 mc take", owner, 2);
    host_try(res, lat);
    chk("R2 refused", res, 2);
    chk("R2 latency", lat, 0);
    chk("R2 owner", owner, 2);
    chk("R2 eng_rst", eng_rst, 0);
    pulse(host_done);
    chk("R6 host_done ignored", owner, 2);
    pulse(mc_drop);
    chk("R7 mc drop", owner, 0);

    // simultaneous
    @(negedge clk); host_acq = 1'b1; mc_take = 1'b1;
    @(negedge clk); host_acq = 1'b0; mc_take = 1'b0;
    chk("R8 owner", owner, 2);
    chk("R8 host_fail", host_fail, 1);
    pulse(mc_drop);

    // timeout with flag stuck low
    mode = 1;
    host_try(res, lat);
    chk("R9 fail", res, 2);
    chk("R9 latency", lat, WL + 1);
    @(negedge clk);
    chk("R9 eng_rst", eng_rst, 0);
    chk("R9 owner", owner, 0);
    settle();

    // timeout with flag stuck high
    mode = 2; dly = 0;
    host_try(res, lat);
    chk("R9 lo fail", res, 2);
    chk("R9 lo owner", owner, 0);
    chk("R4 no grant w/o low", (lat > WL) ? 1 : 0, 1);
    settle();

    // mc takes during sequence
    mode = 1;
    @(negedge clk); host_acq = 1'b1;
    @(negedge clk); host_acq = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 eng_rst mid", eng_rst, 1);
    mc_take = 1'b1;
    @(negedge clk); mc_take = 1'b0;
    chk("R10 host_fail", host_fail, 1);
    chk("R10 eng_rst", eng_rst, 0);
    chk("R10 owner", owner, 2);
    pulse(mc_drop);
    settle();

    // random mix
    exp_own = 0;
    for (int k = 0; k < 40; k++) begin
      op = $urandom_range(3);
      dly = $urandom_range(3);
      mode = 0;
      case (op)
        0: begin
          host_try(res, lat);
          chk("R5 rand result", res, acq_result(exp_own));
          exp_own = next_owner_acq(exp_own);
        end
        1: begin pulse(host_done); if (exp_own == 1) exp_own = 0; end
        2: begin pulse(mc_take);   if (exp_own == 0) exp_own = 2; end
        default: begin pulse(mc_drop); if (exp_own == 2) exp_own = 0; end
      endcase
      chk("R7 rand owner", owner, exp_own);
      repeat (6) @(negedge clk);
    end
    chk("R3 rand order", ord_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule